// File: doc/BRIEF.md
# Shared-Timebase LED Blink Gate Generator

This block produces one blink-gate signal per output port. A port mux elsewhere combines each gate with that port's PWM waveform. All ports share one blink timebase. Each port sets its own on-fraction, in sixteenths of the shared period.

The timebase counts cycles in which `tickEn` is high. `tickEn` is the enable from the selectable timing clock that also feeds the PWM block, so blink timing always follows the same clock source as the PWM. A free-running binary divider counts these ticks. A 3-bit select chooses which four adjacent divider bits act as the current phase index (0 to 15). Because the divider itself is never reloaded, a new period selection takes effect at once. A synchronous clear input resets the divider so that blink timing can be lined up with an external event or with other devices.

Each port compares the phase index with its effective duty value. The result goes to a register, which drives the port's gate.

Top module: `led_blink_gen`

## Requirements
- R1: While `rstN` is low, every bit of `blinkOn` is 0 and the timebase is held at zero.
- R2: For `periodSel` codes 0 to 6, the phase index advances once every 2^(TICK_LOG2-7+code) ticks. The full period is therefore 16 phases, or 2^(TICK_LOG2-3+code) ticks. With TICK_LOG2=15 this gives 1/8 s for code 0, doubling with each code up to 8 s for code 6.
- R3: `periodSel` code 7 selects the fan rate. The phase advances every 2^(TICK_LOG2-9) ticks, so the period is 2^(TICK_LOG2-5) ticks (32 Hz when TICK_LOG2=15).
- R4: Port i's duty is the field `dutyIn[4*i+3:4*i]`. The port's gate is 1 exactly while the phase index is less than its effective duty.
- R5: A duty field of 0 is treated as 1. The effective duty therefore ranges from 1/16 to 15/16: every port is on in phase 0 and off in phase 15.
- R6: The timebase advances by one tick only in cycles where `tickEn` is 1 and `cntClr` is 0. Otherwise it holds its value.
- R7: When `cntClr` is 1, the timebase returns to zero on the next edge, whatever the value of `tickEn`.
- R8: A change of `periodSel` needs no reload. The new phase index is read from the divider as it stands.
- R9: All ports use the same phase index, and each port is compared against its own duty independently of the others.
- R10: `blinkOn` is registered. It reflects the phase, `periodSel` and `dutyIn` values present one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle enable per timing-clock tick |
| cntClr | input | 1 | Synchronous clear of the blink timebase |
| periodSel | input | 3 | Period code: 0..6 from the shortest to the longest period, 7 for the fan rate |
| dutyIn | input | 16 | Four 4-bit per-port duty fields; port i occupies bits 4i+3..4i |
| blinkOn | output | 4 | Registered blink gate, one bit per port |

## Verification
The bench builds the block with TICK_LOG2=9 and the default four ports. With TICK_LOG2=9, even the longest period (code 6) lasts only 4096 ticks. Every period code, including the fan rate, can therefore be run through complete periods and through wraps of the divider within the run. At the same setting, the fan rate advances its phase on every tick, so clears, gaps in `tickEn` and mid-run period changes land on single-tick phase boundaries.

// File: rtl/blink_pkg.sv
package blink_pkg;

  // Sixteen phases per blink period.
  localparam int PHASE_W = 4;

  // Strobes handed from the timebase control to the compare datapath.
  typedef struct packed {
    logic [PHASE_W-1:0] phase;
    logic               firstPhase;
    logic               lastPhase;
  } blinkCtl_t;

endpackage

// File: rtl/blink_ctrl.sv
module blink_ctrl
  import blink_pkg::*;
#(
  parameter int TICK_LOG2 = 15,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             cntClr,
  input  logic [SEL_W-1:0] periodSel,
  output blinkCtl_t        ctl
);

  localparam int NUM_SEL   = 1 << SEL_W;
  localparam int NUM_SLOW  = NUM_SEL - 1;
  // Phase length for slow code k is 2^(BASE_SLOW+k) ticks.
  localparam int BASE_SLOW = TICK_LOG2 - 3 - PHASE_W;
  // Fan rate: the period is 1/32 of a second.
  localparam int BASE_FAN  = TICK_LOG2 - 5 - PHASE_W;
  localparam int DIV_W     = BASE_SLOW + NUM_SLOW - 1 + PHASE_W;

  logic [DIV_W-1:0]   divCnt;
  logic [PHASE_W-1:0] tapPhase [NUM_SEL];
  logic [PHASE_W-1:0] phaseSel;

  // Free-running tick divider; the clear wins over the tick.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (cntClr) begin
      divCnt <= '0;
    end else if (tickEn) begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // Every period code is a four-bit window of the same divider.
  for (genvar k = 0; k < NUM_SLOW; k++) begin : g_slowTap
    assign tapPhase[k] = divCnt[BASE_SLOW+k +: PHASE_W];
  end
  assign tapPhase[NUM_SEL-1] = divCnt[BASE_FAN +: PHASE_W];

  always_comb begin
    phaseSel       = tapPhase[periodSel];
    ctl.phase      = phaseSel;
    ctl.firstPhase = (phaseSel == '0);
    ctl.lastPhase  = (phaseSel == '1);
  end

  // R6: without a tick and without a clear the divider keeps its value
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !cntClr) |=> $stable(divCnt));

  // R6: a tick moves the divider by exactly one
  a_r6_step: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !cntClr) |=> (divCnt == $past(divCnt) + DIV_W'(1)));

  // R7: a clear always lands at zero
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    cntClr |=> (divCnt == '0));

endmodule

// File: rtl/blink_dp.sv
module blink_dp
  import blink_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  blinkCtl_t                    ctl,
  input  logic [NUM_PORTS*PHASE_W-1:0] dutyIn,
  output logic [NUM_PORTS-1:0]         blinkOn
);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic [PHASE_W-1:0] dutyRaw;
    logic [PHASE_W-1:0] dutyEff;

    assign dutyRaw = dutyIn[i*PHASE_W +: PHASE_W];
    // The smallest supported on-fraction is one phase.
    assign dutyEff = (dutyRaw == '0) ? PHASE_W'(1) : dutyRaw;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        blinkOn[i] <= 1'b0;
      end else begin
        blinkOn[i] <= (ctl.phase < dutyEff);
      end
    end
  end

  // R1: the gates stay low while reset is held
  a_r1_reset_low: assert property (@(posedge clk)
    !rstN |-> (blinkOn == '0));

  // R5: every port is on during the first phase
  a_r5_first_on: assert property (@(posedge clk) disable iff (!rstN)
    ctl.firstPhase |=> (&blinkOn));

  // R5: every port is off during the last phase
  a_r5_last_off: assert property (@(posedge clk) disable iff (!rstN)
    ctl.lastPhase |=> (blinkOn == '0));

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen
  import blink_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int TICK_LOG2 = 15,
  parameter int SEL_W     = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         tickEn,
  input  logic                         cntClr,
  input  logic [SEL_W-1:0]             periodSel,
  input  logic [NUM_PORTS*PHASE_W-1:0] dutyIn,
  output logic [NUM_PORTS-1:0]         blinkOn
);

  blinkCtl_t ctl;

  blink_ctrl #(
    .TICK_LOG2 (TICK_LOG2),
    .SEL_W     (SEL_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .cntClr    (cntClr),
    .periodSel (periodSel),
    .ctl       (ctl)
  );

  blink_dp #(
    .NUM_PORTS (NUM_PORTS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .dutyIn  (dutyIn),
    .blinkOn (blinkOn)
  );

endmodule

// File: tb/tb_led_blink_gen.sv
module tb_led_blink_gen;

  localparam int L = 9;

  logic        clk = 1'b0;
  logic        rstN;
  logic        tickEn;
  logic        cntClr;
  logic [2:0]  periodSel;
  logic [15:0] dutyIn;
  logic [3:0]  blinkOn;

  int unsigned modelTicks;
  logic [3:0]  expPending;
  string       curReq;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  led_blink_gen #(.NUM_PORTS(4), .TICK_LOG2(L), .SEL_W(3)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntClr(cntClr),
    .periodSel(periodSel), .dutyIn(dutyIn), .blinkOn(blinkOn)
  );

  // Expected gates from tick count, period code and duty fields (R2..R5).
  function automatic logic [3:0] expVec(int unsigned ticks, logic [2:0] sel,
                                         logic [15:0] duty);
    int shift;
    int unsigned ph;
    logic [3:0] r;
    shift = (sel == 3'd7) ? (L - 9) : (L - 7 + int'(sel));
    ph = (ticks >> shift) & 15;
    for (int i = 0; i < 4; i++) begin
      int d;
      d = int'(duty[i*4 +: 4]);
      if (d == 0) d = 1;
      r[i] = (ph < d);
    end
    return r;
  endfunction

  task automatic check(logic [3:0] exp);
    checks++;
    if (blinkOn !== exp) begin
      errors++;
      $display("FAIL %s: blinkOn=%b expected=%b", curReq, blinkOn, exp);
    end
  endtask

  task automatic step(logic en, logic clr, logic [2:0] sel, logic [15:0] duty);
    @(negedge clk);
    check(expPending);
    tickEn    = en;
    cntClr    = clr;
    periodSel = sel;
    dutyIn    = duty;
    expPending = expVec(modelTicks, sel, duty);
    if (clr) modelTicks = 0;
    else if (en) modelTicks++;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 1'b0; tickEn = 1'b1; cntClr = 1'b0; periodSel = 3'd0;
    dutyIn = 16'hF841;
    modelTicks = 0;

    // R1: reset holds all gates low even with ticks applied
    curReq = "R1";
    repeat (4) begin
      @(negedge clk);
      check(4'b0000);
    end
    rstN = 1'b1;
    tickEn = 1'b0;
    expPending = expVec(0, periodSel, dutyIn);

    // R2/R9: shortest period, four different duties, two full periods
    curReq = "R2_R9";
    repeat (128) step(1'b1, 1'b0, 3'd0, 16'hF841);

    // R5: zero duty acts as one sixteenth; duty 15 ends before the last phase
    curReq = "R5";
    repeat (128) step(1'b1, 1'b0, 3'd0, 16'h0F00);

    // R3: fan rate
    curReq = "R3";
    repeat (80) step(1'b1, 1'b0, 3'd7, 16'h3C96);

    // R2: longest period over one complete period
    curReq = "R2";
    repeat (4100) step(1'b1, 1'b0, 3'd6, 16'h2B75);

    // R10: with the phase frozen, a duty change shows after exactly one edge
    curReq = "R10";
    step(1'b1, 1'b1, 3'd7, 16'h0000);
    repeat (5) step(1'b1, 1'b0, 3'd7, 16'h0000);
    repeat (3) step(1'b0, 1'b0, 3'd7, 16'h4444);
    repeat (3) step(1'b0, 1'b0, 3'd7, 16'h8888);

    // R7: a clear together with a tick still restarts at phase 0
    curReq = "R7";
    repeat (20) step(1'b1, 1'b0, 3'd7, 16'h1234);
    step(1'b1, 1'b1, 3'd7, 16'h1234);
    repeat (6) step(1'b1, 1'b0, 3'd7, 16'h1234);

    // R6: sparse ticks
    curReq = "R6";
    repeat (3000) step(1'($urandom_range(0, 1)), 1'b0, 3'd2, 16'h5A3F);

    // R7: random clears
    curReq = "R7";
    repeat (3000) step(1'b1, ($urandom_range(0, 99) < 3), 3'd1, 16'hE6C2);

    // R8: period changes in the middle of a running timebase
    curReq = "R8";
    for (int seg = 0; seg < 60; seg++) begin
      logic [2:0] s;
      s = 3'($urandom_range(0, 7));
      repeat ($urandom_range(5, 120)) step(1'b1, 1'b0, s, 16'h9F17);
    end

    // R4: everything random
    curReq = "R4";
    for (int n = 0; n < 20000; n++) begin
      step(($urandom_range(0, 3) != 0), ($urandom_range(0, 499) == 0),
           3'($urandom_range(0, 7)), 16'($urandom()));
    end

    @(negedge clk);
    check(expPending);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule